// File: doc/BRIEF.md
# Receive Halfband Decimator and Matched Filter

This block sits at the start of a QPSK receive path. Complex baseband samples arrive as separate I and Q words, each with a shared valid strobe. A 19-tap halfband FIR first halves the sample rate. A 81-tap root-raised-cosine filter then shapes the decimated stream. That filter runs at four samples per symbol and uses a roll-off of 1. Its output feeds a later symbol timing recovery stage, which is not part of this block.

The halfband stage uses the same side coefficients as the transmit-side 2x interpolators, and they are passed in as a parameter. It calculates a result only on every second accepted input. It skips the taps whose value is zero by construction. The matched filter calculates one result per decimated sample. It adds mirrored samples before multiplying, so it needs 41 products per output. Each stage rounds and saturates its result to the output width. The halfband delay is 9 input samples. The matched filter delay is 40 decimated samples.

Top module: `rx_hb_rrc_filter`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid` is 0 and `out_i`, `out_q` are 0. All filter history is zero after reset.
- R2: The halfband stage produces exactly one result for every two accepted inputs (inputs with `in_valid` high), on the 2nd, 4th, 6th input and so on after reset. Cycles with `in_valid` low do not count, shift nothing and produce no output.
- R3: The halfband output is y = sum over k = 0..18 of h[k]·x[n−k], where x[n] is the newest accepted input. The coefficients are in Q15: h[9] = 16384, and h[9±d] for d = 1,3,5,7,9 = 10266, −3011, 1370, −590, 184. The taps at even d ≠ 0 are zero.
- R4: The matched filter output is z = sum over n = −40..40 of g[n]·y[m−n], in Q13, where y[m] is the newest decimated sample. The taps are g[0] = 10430 and g[±1] = 8192. Every other odd n gives 0. For n = 2j with j ≠ 0, g[n] = round(10430 / (4j²−1)), positive when j is odd and negative when j is even. This is the sampled root-raised-cosine with roll-off 1.
- R5: Each stage rounds by adding half an LSB of the final scale and then shifting right arithmetically. For example, Q15 adds 16384 and shifts by 15. This rounds ties toward +∞.
- R6: Each stage saturates its rounded result to the range −32768..32767 before passing it on.
- R7: A result appears on `out_valid` two clock cycles after the cycle in which the completing (even-numbered) input is presented. `out_i` and `out_q` keep their values in every cycle without a new result.
- R8: The I and Q paths are filtered independently with identical coefficients. A sample on one channel never affects the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | 16 | In-phase input sample, two's complement |
| in_q | input | 16 | Quadrature input sample, two's complement |
| out_valid | output | 1 | Filtered sample strobe, one per two accepted inputs |
| out_i | output | 16 | Filtered in-phase sample |
| out_q | output | 16 | Filtered quadrature sample |

## Verification
The bench applies impulses on one channel at a time. A design that mixed up the channels or mis-indexed a mirrored tap pair would produce the wrong impulse response, or leak energy into the quiet channel. Streams with irregular gaps in `in_valid` test decimation phase tracking. A design that counted idle cycles, or started on the odd input, would emit results at the wrong times or from the wrong sample pairs. Full-scale constant inputs push both stages past their limits, so a design that wrapped instead of saturating shows up at once. Small-amplitude noise keeps results near rounding ties, which exposes truncation or round-toward-zero.

// File: rtl/rxfe_pkg.sv
package rxfe_pkg;

   // Sampled root-raised-cosine tap, roll-off 1, four samples per symbol.
   // n is the offset in samples, unity is the value of the tap at n = +/-1.
   function automatic int rrc_tap(input int n, input int unity);
      int peak;
      int j;
      int d;
      int mag;
      peak = (unity * 452 + 177) / 355;      // unity * 4 / pi
      if (n == 0) return peak;
      if (n == 1 || n == -1) return unity;
      if ((n % 2) != 0) return 0;
      j   = n / 2;
      d   = 4 * j * j - 1;
      mag = (peak + d / 2) / d;
      return ((j % 2) != 0) ? mag : -mag;
   endfunction

   // Round half up at 2^-frac, then clamp to a signed ow-bit range.
   function automatic longint round_sat(input longint acc, input int frac, input int ow);
      longint r;
      longint hi;
      longint lo;
      r  = (acc + (longint'(1) <<< (frac - 1))) >>> frac;
      hi = (longint'(1) <<< (ow - 1)) - 1;
      lo = -hi - 1;
      if (r > hi) r = hi;
      else if (r < lo) r = lo;
      return r;
   endfunction

endpackage

// File: rtl/rxfe_hb_decim.sv
module rxfe_hb_decim
   import rxfe_pkg::*;
#(
   parameter int DW     = 16,
   parameter int CH     = 2,
   parameter int CW     = 18,
   parameter int FRAC   = 15,
   parameter int NSIDE  = 5,
   parameter int CENTER = 16384,
   parameter logic [NSIDE*CW-1:0] SIDE = {18'sd184, -18'sd590, 18'sd1370, -18'sd3011, 18'sd10266}
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic signed [DW-1:0] din  [CH],
   output logic                 out_valid,
   output logic signed [DW-1:0] dout [CH]
);
   localparam int LEN   = 4 * NSIDE - 1;
   localparam int MID   = 2 * NSIDE - 1;
   localparam int PW    = DW + 1;
   localparam int ACC_W = PW + CW + $clog2(NSIDE + 1);
   localparam logic signed [CW-1:0] CTR = CW'(CENTER);

   if (ACC_W > 64) begin : g_acc_too_wide
      $error("halfband accumulator exceeds 64 bits");
   end
   if (NSIDE < 1 || FRAC < 1) begin : g_bad_shape
      $error("halfband needs NSIDE >= 1 and FRAC >= 1");
   end

   logic                 phase;
   logic signed [DW-1:0] res [CH];

   for (genvar c = 0; c < CH; c++) begin : g_ch
      logic signed [DW-1:0]    hist [LEN-1];
      logic signed [PW-1:0]    pre  [NSIDE+1];
      logic signed [PW+CW-1:0] prod [NSIDE+1];
      logic signed [ACC_W-1:0] acc;

      for (genvar i = 0; i < NSIDE; i++) begin : g_side
         localparam logic signed [CW-1:0] CI = SIDE[i*CW +: CW];
         localparam int NEAR = MID - (2 * i + 1);
         localparam int FAR  = MID + (2 * i + 1);
         if (NEAR == 0) begin : g_newest
            assign pre[i] = PW'(din[c]) + PW'(hist[FAR-1]);
         end else begin : g_stored
            assign pre[i] = PW'(hist[NEAR-1]) + PW'(hist[FAR-1]);
         end
         assign prod[i] = pre[i] * CI;
      end
      assign pre[NSIDE]  = PW'(hist[MID-1]);
      assign prod[NSIDE] = pre[NSIDE] * CTR;

      always_comb begin
         acc = '0;
         for (int j = 0; j <= NSIDE; j++) acc += ACC_W'(prod[j]);
      end
      assign res[c] = DW'(round_sat(longint'(acc), FRAC, DW));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int k = 0; k < LEN - 1; k++) hist[k] <= '0;
         end else if (in_valid) begin
            hist[0] <= din[c];
            for (int k = 1; k < LEN - 1; k++) hist[k] <= hist[k-1];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase     <= 1'b0;
         out_valid <= 1'b0;
         for (int c = 0; c < CH; c++) dout[c] <= '0;
      end else begin
         out_valid <= in_valid && phase;
         if (in_valid) phase <= ~phase;
         if (in_valid && phase) begin
            for (int c = 0; c < CH; c++) dout[c] <= res[c];
         end
      end
   end
endmodule

// File: rtl/rxfe_rrc_mf.sv
module rxfe_rrc_mf
   import rxfe_pkg::*;
#(
   parameter int DW    = 16,
   parameter int CH    = 2,
   parameter int CW    = 18,
   parameter int FRAC  = 13,
   parameter int HALF  = 40,
   parameter int UNITY = 8192
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic signed [DW-1:0] din  [CH],
   output logic                 out_valid,
   output logic signed [DW-1:0] dout [CH]
);
   localparam int LEN   = 2 * HALF + 1;
   localparam int PW    = DW + 1;
   localparam int ACC_W = PW + CW + $clog2(HALF + 2);

   if (ACC_W > 64) begin : g_acc_too_wide
      $error("matched filter accumulator exceeds 64 bits");
   end
   if (HALF < 1 || FRAC < 1) begin : g_bad_shape
      $error("matched filter needs HALF >= 1 and FRAC >= 1");
   end

   logic signed [DW-1:0] res [CH];

   for (genvar c = 0; c < CH; c++) begin : g_ch
      logic signed [DW-1:0]    hist [LEN-1];
      logic signed [DW-1:0]    win  [LEN];
      logic signed [PW-1:0]    pre  [HALF+1];
      logic signed [PW+CW-1:0] prod [HALF+1];
      logic signed [ACC_W-1:0] acc;

      assign win[0] = din[c];
      for (genvar k = 1; k < LEN; k++) begin : g_win
         assign win[k] = hist[k-1];
      end

      for (genvar k = 0; k <= HALF; k++) begin : g_tap
         localparam logic signed [CW-1:0] CK = CW'(rrc_tap(k - HALF, UNITY));
         if (k == HALF) begin : g_mid
            assign pre[k] = PW'(win[k]);
         end else begin : g_pair
            assign pre[k] = PW'(win[k]) + PW'(win[LEN-1-k]);
         end
         assign prod[k] = pre[k] * CK;
      end

      always_comb begin
         acc = '0;
         for (int j = 0; j <= HALF; j++) acc += ACC_W'(prod[j]);
      end
      assign res[c] = DW'(round_sat(longint'(acc), FRAC, DW));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int k = 0; k < LEN - 1; k++) hist[k] <= '0;
         end else if (in_valid) begin
            hist[0] <= din[c];
            for (int k = 1; k < LEN - 1; k++) hist[k] <= hist[k-1];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         for (int c = 0; c < CH; c++) dout[c] <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            for (int c = 0; c < CH; c++) dout[c] <= res[c];
         end
      end
   end
endmodule

// File: rtl/rx_hb_rrc_filter.sv
module rx_hb_rrc_filter #(
   parameter int DATA_W    = 16,
   parameter int HB_CW     = 18,
   parameter int HB_FRAC   = 15,
   parameter int HB_NSIDE  = 5,
   parameter int HB_CENTER = 16384,
   parameter logic [HB_NSIDE*HB_CW-1:0] HB_SIDE =
      {18'sd184, -18'sd590, 18'sd1370, -18'sd3011, 18'sd10266},
   parameter int RRC_CW    = 18,
   parameter int RRC_FRAC  = 13,
   parameter int RRC_HALF  = 40,
   parameter int RRC_UNITY = 8192
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic signed [DATA_W-1:0] in_i,
   input  logic signed [DATA_W-1:0] in_q,
   output logic                     out_valid,
   output logic signed [DATA_W-1:0] out_i,
   output logic signed [DATA_W-1:0] out_q
);
   localparam int NCH = 2;

   if (DATA_W < 2 || DATA_W > 32) begin : g_bad_width
      $error("DATA_W must lie in 2..32");
   end
   if (HB_CENTER >= (1 << (HB_CW - 1))) begin : g_bad_center
      $error("HB_CENTER does not fit HB_CW");
   end

   logic signed [DATA_W-1:0] in_ch  [NCH];
   logic signed [DATA_W-1:0] hb_ch  [NCH];
   logic signed [DATA_W-1:0] mf_ch  [NCH];
   logic                     hb_valid;

   assign in_ch[0] = in_i;
   assign in_ch[1] = in_q;

   rxfe_hb_decim #(
      .DW(DATA_W), .CH(NCH), .CW(HB_CW), .FRAC(HB_FRAC),
      .NSIDE(HB_NSIDE), .CENTER(HB_CENTER), .SIDE(HB_SIDE)
   ) hb_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .din(in_ch),
      .out_valid(hb_valid), .dout(hb_ch)
   );

   rxfe_rrc_mf #(
      .DW(DATA_W), .CH(NCH), .CW(RRC_CW), .FRAC(RRC_FRAC),
      .HALF(RRC_HALF), .UNITY(RRC_UNITY)
   ) mf_i (
      .clk(clk), .rst_n(rst_n), .in_valid(hb_valid), .din(hb_ch),
      .out_valid(out_valid), .dout(mf_ch)
   );

   assign out_i = mf_ch[0];
   assign out_q = mf_ch[1];
endmodule

// File: rtl/rx_hb_rrc_filter_chk.sv
module rx_hb_rrc_filter_chk #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              hb_valid,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_i,
   input logic [DATA_W-1:0] out_q
);
   p_hb_needs_input_r2: assert property (@(posedge clk) disable iff (!rst_n)
      hb_valid |-> $past(in_valid));

   p_hb_never_twice_r2: assert property (@(posedge clk) disable iff (!rst_n)
      hb_valid |=> !hb_valid);

   p_idle_gives_nothing_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !hb_valid);

   p_out_after_hb_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(hb_valid));

   p_out_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !hb_valid |=> ($stable(out_i) && $stable(out_q)));
endmodule

bind rx_hb_rrc_filter rx_hb_rrc_filter_chk #(.DATA_W(DATA_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .hb_valid(hb_valid),
   .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
);

// File: tb/rx_hb_rrc_filter_tb_top.sv
module rx_hb_rrc_filter_tb_top;
   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               in_valid = 1'b0;
   logic signed [15:0] in_i = '0;
   logic signed [15:0] in_q = '0;
   logic               out_valid;
   logic signed [15:0] out_i;
   logic signed [15:0] out_q;

   int     errors = 0;
   int     checks = 0;
   longint cyc = 0;
   bit     mon_en = 1'b0;
   bit     done = 1'b0;
   int     last_i = 0;
   int     last_q = 0;

   typedef struct { int i; int q; longint due; } exp_t;
   exp_t sb[$];

   int hx [2][19];
   int rx [2][81];
   int n_in = 0;
   int hb_side [5] = '{10266, -3011, 1370, -590, 184};

   always #10 clk = ~clk;   // 50 MHz
   always @(posedge clk) cyc <= cyc + 1;

   rx_hb_rrc_filter dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
      .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int hb_coef(input int k);
      int d;
      d = (k > 9) ? k - 9 : 9 - k;
      if (d == 0) return 16384;
      if ((d % 2) == 0) return 0;
      return hb_side[(d - 1) / 2];
   endfunction

   function automatic int mf_coef(input int n);
      int j;
      int d;
      int mag;
      if (n == 0) return 10430;
      if (n == 1 || n == -1) return 8192;
      if ((n % 2) != 0) return 0;
      j = n / 2;
      d = 4 * j * j - 1;
      mag = (10430 + d / 2) / d;
      return ((j % 2) != 0) ? mag : -mag;
   endfunction

   function automatic int rs(input longint a, input int f);
      longint r;
      r = (a + (longint'(1) <<< (f - 1))) >>> f;
      if (r > 32767) r = 32767;
      if (r < -32768) r = -32768;
      return int'(r);
   endfunction

   // Reference model: R3 R4 R5 R6 R8
   task automatic model(input int xi, input int xq, input longint due);
      int     xs [2];
      int     ys [2];
      int     zs [2];
      longint acc;
      exp_t   e;
      xs[0] = xi;
      xs[1] = xq;
      n_in++;
      for (int c = 0; c < 2; c++) begin
         for (int k = 18; k > 0; k--) hx[c][k] = hx[c][k-1];
         hx[c][0] = xs[c];
      end
      if ((n_in % 2) == 0) begin
         for (int c = 0; c < 2; c++) begin
            acc = 0;
            for (int k = 0; k < 19; k++) acc += longint'(hb_coef(k)) * hx[c][k];
            ys[c] = rs(acc, 15);
            for (int k = 80; k > 0; k--) rx[c][k] = rx[c][k-1];
            rx[c][0] = ys[c];
            acc = 0;
            for (int k = 0; k < 81; k++) acc += longint'(mf_coef(k - 40)) * rx[c][k];
            zs[c] = rs(acc, 13);
         end
         e.i = zs[0];
         e.q = zs[1];
         e.due = due;
         sb.push_back(e);
      end
   endtask

   task automatic drive(input bit v, input int xi, input int xq);
      @(posedge clk);
      #2;
      in_valid = v;
      in_i = 16'(xi);
      in_q = 16'(xq);
      if (v) model(xi, xq, cyc + 2);
   endtask

   function automatic int rnd16();
      return int'($urandom_range(65535)) - 32768;
   endfunction

   // Scoreboard monitor
   always @(negedge clk) begin
      if (mon_en) begin
         if (out_valid) begin
            if (sb.size() == 0) begin
               chk(1'b0, "R2", "unexpected output strobe", 1, 0);
            end else begin
               exp_t e;
               e = sb.pop_front();
               chk(cyc == e.due, "R7", "result cycle", cyc, e.due);
               chk(int'(out_i) == e.i, "R3 R4 R5 R6 R8", "out_i", out_i, e.i);
               chk(int'(out_q) == e.q, "R3 R4 R5 R6 R8", "out_q", out_q, e.q);
            end
            last_i = out_i;
            last_q = out_q;
         end else begin
            if (sb.size() != 0 && sb[0].due < cyc)
               chk(1'b0, "R2", "missing output strobe", 0, 1);
            chk(int'(out_i) == last_i && int'(out_q) == last_q, "R7", "hold between results",
                out_i, last_i);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL R2 watchdog: actual running expected finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      for (int c = 0; c < 2; c++) begin
         for (int k = 0; k < 19; k++) hx[c][k] = 0;
         for (int k = 0; k < 81; k++) rx[c][k] = 0;
      end
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk(out_valid == 1'b0, "R1", "out_valid during reset", out_valid, 0);
      @(posedge clk);
      #2;
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
      chk(out_i == 0 && out_q == 0, "R1", "outputs after reset", out_i, 0);
      mon_en = 1'b1;

      // R3 R4 R8: impulse on I only, then on Q only at an odd position
      drive(1'b1, 20000, 0);
      for (int n = 0; n < 200; n++) drive(1'b1, 0, 0);
      drive(1'b1, 0, -15000);
      for (int n = 0; n < 200; n++) drive(1'b1, 0, 0);

      // R3 R4 R5: full-range random stream
      for (int n = 0; n < 400; n++) drive(1'b1, rnd16(), rnd16());

      // R2: irregular valid gaps with random data
      for (int n = 0; n < 300; n++) drive(1'($urandom_range(1)), rnd16(), rnd16());

      // R5: small values near rounding ties
      for (int n = 0; n < 200; n++)
         drive(1'b1, int'($urandom_range(16)) - 8, int'($urandom_range(16)) - 8);

      // R6: full-scale drive into both stages, both polarities
      for (int n = 0; n < 150; n++) drive(1'b1, 32767, -32768);
      for (int n = 0; n < 150; n++) drive(1'b1, -32768, 32767);

      // R2: idle cycles produce no further results
      for (int n = 0; n < 10; n++) drive(1'b0, 1234, -1234);
      @(negedge clk);
      chk(sb.size() == 0, "R2", "results outstanding at end", sb.size(), 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule